// File: doc/BRIEF.md
# Watchdog Timer with Guarded Reload

This block is a watchdog timer that a processor talks to through a small register port. Software loads a time-out constant, turns the watchdog on, and must then keep reloading the down-counter by writing a two-step key (first 0xAA, then 0x55) to a dedicated feed location. The count is reloaded only by that exact pair of consecutive accesses. If the counter runs out, the block raises a one-cycle interrupt pulse and, if software asked for it, a one-cycle reset request.

Turning the enable bit on does not yet start the countdown. The watchdog becomes live only after the first complete key pair that follows the enable. From then on, any register access that lands between the two halves of the key counts as tampering and produces a fault pulse two clocks later. Before that point, broken key sequences are silently ignored. The counter advances on a tick that is the block clock divided by a parameter (four by default). The time-out constant never holds a value below a parameterised floor (0xFF by default).

Top module: `wdg_top`

## Requirements
- R1: After reset the mode register (offset 0x0) reads 0, the constant register (offset 0x4) reads 0xFF, the count register (offset 0xC) reads 0xFF, and both pulse outputs are low.
- R2: A write to the constant register stores the written value, or 0xFF if that value is below 0xFF. The stored value reads back at offset 0x4.
- R3: A write of 0xAA to the feed register (offset 0x8), followed by a write of 0x55 there as the very next access, loads the count with the constant. The count reads the constant in the cycle after the 0x55 write, whether or not the watchdog is enabled.
- R4: The counter does not move and no pulse appears until the watchdog is armed. Arming takes a valid key pair completed while enable (mode bit 0) is set. Setting enable alone, or a key pair completed while enable is clear, does not arm it.
- R5: Before arming, a 0xAA write followed by any access other than a 0x55 feed write produces no pulse on either output.
- R6: Once armed, the count decreases by exactly one every TICK_DIV clock cycles and never skips a value.
- R7: When the count steps from 1 to 0, the interrupt output is high for exactly the one cycle in which the count first reads 0. The count then stays at 0 until the next valid key pair.
- R8: The time-out flag (mode bit 2) sets on that expiry and stays set until reset. Writing 0 to bit 2 does not clear it.
- R9: Enable (mode bit 0) and reset-enable (mode bit 1) can be set by a mode write but are not cleared by writing 0.
- R10: Once armed, if a 0xAA feed write is followed by any access that is not a 0x55 feed write, the interrupt output pulses for one cycle. That cycle follows the second rising edge, counting the edge that accepts the offending access as the first.
- R11: The reset request output pulses together with every interrupt pulse when reset-enable is set, and stays low otherwise.
- R12: Read data follows the address combinationally, whether or not the access strobe is high. The feed location and any address with nonzero low two bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_en | input | 1 | Register access strobe, one access per cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte offset: 0x0 mode, 0x4 constant, 0x8 feed, 0xC count |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data of the addressed register |
| wdt_irq | output | 1 | One-cycle time-out or fault pulse |
| wdt_rst_req | output | 1 | One-cycle reset request, gated by reset-enable |

## Verification
The bench builds the block with CNT_W = 16, TICK_DIV = 4 and MIN_LOAD = 0xFF. This keeps a full time-out near a thousand cycles, so several complete countdowns can be followed one value at a time, with the tick spacing checked between every pair of steps. The narrower data path lets the bench sweep every constant value from 0 up past the clamp floor and compare each read-back against the arithmetic clamp. The fault timing is checked cycle by cycle for three different kinds of interrupting access, both before and after arming.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    IDX_MODE = 2'd0,
    IDX_LOAD = 2'd1,
    IDX_FEED = 2'd2,
    IDX_CNT  = 2'd3
  } wdg_idx_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  localparam int MB_EN    = 0;
  localparam int MB_RSTEN = 1;
  localparam int MB_TOF   = 2;
endpackage

// File: rtl/wdg_tick.sv
module wdg_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] div_q, div_d;

  always_comb begin
    div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
    tick  = (div_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/wdg_feed.sv
module wdg_feed
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_en,
  input  logic       acc_we,
  input  logic       sel_feed,
  input  logic [7:0] wdata_lo,
  input  logic       enable,
  output logic       reload,
  output logic       armed,
  output logic       fault
);
  logic pend_q, pend_d;
  logic armed_q, armed_d;
  logic fault_q, fault_d;
  logic feed_wr, start, good, bad;

  always_comb begin
    feed_wr = acc_en & acc_we & sel_feed;
    start   = ~pend_q & feed_wr & (wdata_lo == KEY_FIRST);
    good    = pend_q & feed_wr & (wdata_lo == KEY_SECOND);
    bad     = pend_q & acc_en & ~good;
    pend_d  = acc_en ? start : pend_q;
    armed_d = armed_q | (good & enable);
    fault_d = bad & armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      armed_q <= armed_d;
      fault_q <= fault_d;
    end
  end

  assign reload = good;
  assign armed  = armed_q;
  assign fault  = fault_q;
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int CNT_W    = 32,
  parameter int MIN_LOAD = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             armed,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(MIN_LOAD);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  always_comb begin
    step   = armed & tick & (cnt_q != '0) & ~reload;
    expire = step & (cnt_q == ONE);
    if (reload)    cnt_d = load_val;
    else if (step) cnt_d = cnt_q - ONE;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_CNT;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int TICK_DIV = 4,
  parameter int MIN_LOAD = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_en,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             wdt_irq,
  output logic             wdt_rst_req
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_LOAD);

  logic [1:0]       rsync_q;
  logic             rst_sync_n;
  logic             aligned;
  wdg_idx_e         idx;
  logic             sel_mode, sel_load, sel_feed, sel_cnt;
  logic             en_q, en_d, rsten_q, rsten_d, tof_q, tof_d;
  logic [CNT_W-1:0] load_q, load_d;
  logic             irq_q, irq_d, rreq_q, rreq_d;
  logic             tick, reload, armed, fault, expire;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  always_comb begin
    aligned  = (reg_addr[1:0] == 2'b00);
    idx      = wdg_idx_e'(reg_addr[3:2]);
    sel_mode = aligned & (idx == IDX_MODE);
    sel_load = aligned & (idx == IDX_LOAD);
    sel_feed = aligned & (idx == IDX_FEED);
    sel_cnt  = aligned & (idx == IDX_CNT);
  end

  wdg_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick)
  );

  wdg_feed u_feed (
    .clk(clk), .rst_n(rst_sync_n), .acc_en(reg_en), .acc_we(reg_we),
    .sel_feed(sel_feed), .wdata_lo(reg_wdata[7:0]), .enable(en_q),
    .reload(reload), .armed(armed), .fault(fault)
  );

  wdg_count #(.CNT_W(CNT_W), .MIN_LOAD(MIN_LOAD)) u_count (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .armed(armed),
    .reload(reload), .load_val(load_q), .cnt(cnt), .expire(expire)
  );

  always_comb begin
    en_d    = en_q;
    rsten_d = rsten_q;
    load_d  = load_q;
    if (reg_en && reg_we && sel_mode) begin
      en_d    = en_q    | reg_wdata[MB_EN];
      rsten_d = rsten_q | reg_wdata[MB_RSTEN];
    end
    if (reg_en && reg_we && sel_load)
      load_d = (reg_wdata < FLOOR) ? FLOOR : reg_wdata;
    tof_d  = tof_q | expire;
    irq_d  = expire | fault;
    rreq_d = (expire | fault) & rsten_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q    <= 1'b0;
      rsten_q <= 1'b0;
      tof_q   <= 1'b0;
      load_q  <= FLOOR;
      irq_q   <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      en_q    <= en_d;
      rsten_q <= rsten_d;
      tof_q   <= tof_d;
      load_q  <= load_d;
      irq_q   <= irq_d;
      rreq_q  <= rreq_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_mode) begin
      reg_rdata[MB_EN]    = en_q;
      reg_rdata[MB_RSTEN] = rsten_q;
      reg_rdata[MB_TOF]   = tof_q;
    end else if (sel_load) begin
      reg_rdata = load_q;
    end else if (sel_cnt) begin
      reg_rdata = cnt;
    end
  end

  assign wdt_irq     = irq_q;
  assign wdt_rst_req = rreq_q;
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
  parameter int CNT_W    = 32,
  parameter int MIN_LOAD = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             rst_req,
  input logic             armed,
  input logic             en,
  input logic             rsten,
  input logic             tof,
  input logic             reload,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load_val
);
  AST_LOAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    load_val >= CNT_W'(MIN_LOAD)); // R2
  AST_HOLD_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !reload) |=> $stable(cnt)); // R4
  AST_PULSE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> armed); // R5
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !reload) |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - 1'b1)); // R6
  AST_TOF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tof |=> tof); // R8
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en); // R9
  AST_RSTEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rsten |=> rsten); // R9
  AST_RREQ_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> irq); // R11
  AST_RREQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(rsten)); // R11
endmodule

bind wdg_top wdg_chk #(.CNT_W(CNT_W), .MIN_LOAD(MIN_LOAD)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .irq(wdt_irq), .rst_req(wdt_rst_req),
  .armed(armed), .en(en_q), .rsten(rsten_q), .tof(tof_q),
  .reload(reload), .cnt(cnt), .load_val(load_q)
);

// File: tb/tb_wdg_top.sv
module tb_wdg_top;
  localparam int W   = 16;
  localparam int DIV = 4;
  localparam int FLR = 255;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_en = 1'b0, reg_we = 1'b0;
  logic [3:0]   reg_addr = 4'h0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         wdt_irq, wdt_rst_req;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wdg_top #(.CNT_W(W), .TICK_DIV(DIV), .MIN_LOAD(FLR)) dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [3:0] a, input logic [W-1:0] d);
    reg_en = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [W-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Bad-feed timing: pulse only in the second cycle after the access edge (R10/R11)
  task automatic bad_feed(input logic we, input logic [3:0] a, input logic [W-1:0] d,
                          input logic exp_irq, input logic exp_rst, input string req);
    access(1'b1, 4'h8, 16'h00AA);
    access(we, a, d);
    chk({req, " cycle1 irq"}, wdt_irq, 0);
    @(negedge clk);
    chk({req, " cycle2 irq"}, wdt_irq, exp_irq);
    chk({req, " cycle2 rst"}, wdt_rst_req, exp_rst);
    @(negedge clk);
    chk({req, " cycle3 irq"}, wdt_irq, 0);
  endtask

  task automatic run_out(input int c, input logic exp_rst);
    logic [W-1:0] v;
    int prev, since, steps;
    bit done;
    access(1'b1, 4'h4, W'(c));
    access(1'b1, 4'h8, 16'h00AA);
    access(1'b1, 4'h8, 16'h0055);
    peek(4'hC, v);
    chk("R3 reload value", v, c);
    prev = c; since = 0; steps = 0; done = 0;
    for (int i = 0; i < 4 * c + 40 && !done; i++) begin
      @(negedge clk);
      since++;
      peek(4'hC, v);
      if (int'(v) != prev) begin
        chk("R6 step size", v, prev - 1);
        if (steps > 0) chk("R6 tick spacing", since, DIV);
        else if (since > DIV) chk("R6 first step", since, DIV);
        steps++; since = 0; prev = int'(v);
        if (v == 0) begin
          chk("R7 irq at zero", wdt_irq, 1);
          chk("R11 rst with irq", wdt_rst_req, exp_rst);
          done = 1;
        end
      end
      if (v != 0 && wdt_irq) chk("R7 early irq", 1, 0);
    end
    chk("R6 step count", steps, c);
    @(negedge clk);
    peek(4'hC, v);
    chk("R7 irq one cycle", wdt_irq, 0);
    chk("R7 count held", v, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(4'h0, v); chk("R1 mode", v, 0);
    peek(4'h4, v); chk("R1 const", v, 16'h00FF);
    peek(4'hC, v); chk("R1 count", v, 16'h00FF);
    chk("R1 irq", wdt_irq, 0);
    chk("R1 rst", wdt_rst_req, 0);

    // R2 clamp sweep
    for (int x = 0; x <= 300; x++) begin
      access(1'b1, 4'h4, W'(x));
      peek(4'h4, v);
      chk("R2 clamp", v, (x < FLR) ? FLR : x);
    end
    access(1'b1, 4'h4, 16'hFFFF);
    peek(4'h4, v); chk("R2 max", v, 16'hFFFF);

    // R12 combinational read, feed and misaligned read zero
    peek(4'h8, v); chk("R12 feed reads 0", v, 0);
    peek(4'h5, v); chk("R12 misaligned 0", v, 0);

    // R3/R4 feed without enable reloads but does not arm
    access(1'b1, 4'h4, 16'h0100);
    access(1'b1, 4'h8, 16'h00AA);
    access(1'b1, 4'h8, 16'h0055);
    peek(4'hC, v); chk("R3 reload disabled", v, 16'h0100);
    repeat (20) @(negedge clk);
    peek(4'hC, v); chk("R4 hold no enable", v, 16'h0100);

    // R4 enable alone does not arm
    access(1'b1, 4'h0, 16'h0001);
    peek(4'h0, v); chk("R9 en set", v, 1);
    repeat (20) @(negedge clk);
    peek(4'hC, v); chk("R4 hold enable only", v, 16'h0100);

    // R5 broken feeds before arming are ignored
    bad_feed(1'b0, 4'h4, '0, 1'b0, 1'b0, "R5 read");
    bad_feed(1'b1, 4'h8, 16'h0012, 1'b0, 1'b0, "R5 wrong key");
    peek(4'hC, v); chk("R5 count untouched", v, 16'h0100);

    // R6/R7 first countdown, reset-enable clear
    run_out(256, 1'b0);
    peek(4'h0, v); chk("R8 tof set", v, 5);
    access(1'b1, 4'h0, 16'h0000);
    peek(4'h0, v); chk("R8 R9 sticky bits", v, 5);

    // R3 mid-count reload
    access(1'b1, 4'h4, 16'h0120);
    access(1'b1, 4'h8, 16'h00AA);
    access(1'b1, 4'h8, 16'h0055);
    repeat (100) @(negedge clk);
    access(1'b1, 4'h8, 16'h00AA);
    access(1'b1, 4'h8, 16'h0055);
    peek(4'hC, v); chk("R3 mid reload", v, 16'h0120);

    // R10 armed faults
    bad_feed(1'b0, 4'h4, '0, 1'b1, 1'b0, "R10 read");
    bad_feed(1'b1, 4'h4, 16'h0300, 1'b1, 1'b0, "R10 other write");
    bad_feed(1'b1, 4'h8, 16'h00AA, 1'b1, 1'b0, "R10 repeated key");

    // R11 reset-enable
    access(1'b1, 4'h0, 16'h0002);
    peek(4'h0, v); chk("R9 rsten set", v, 7);
    run_out(255, 1'b1);
    bad_feed(1'b0, 4'hC, '0, 1'b1, 1'b1, "R11 fault rst");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule